// File: doc/BRIEF.md
# DDR2 Bank Command Timing Gate

This block sits between a memory controller's command scheduler and the DRAM command bus. The scheduler presents one command at a time on a valid/ready stream: an operation code and a bank number. The gate keeps a row-open flag and a set of down-counters for every bank, plus two counters shared across banks. It raises `cmd_ready` only when every minimum spacing that applies to the presented command has run out. A command is issued on the cycle where `cmd_valid` and `cmd_ready` are both high. Back-pressure rule: while `cmd_ready` is low, the scheduler must hold the command stable and keep `cmd_valid` high, or withdraw it. Nothing is queued inside the gate. `cmd_ready` depends only on the presented operation, the presented bank and the gate's state, so it may be read before `cmd_valid` is raised.

The gate supports posted column commands. Read latency is the additive latency plus the CAS latency, and write latency is one clock less than read latency. Every burst is four beats, which is two clocks. For each issued READ the gate drives a two-clock `rd_data_valid` window, and for each issued WRITE a two-clock `wr_data_en` window.

All spacings and latencies come in as clock counts on configuration pins. They are captured while reset is held, and the captured copy is used until the next reset.

Top module: `ddr2_cmd_gate`

## Requirements
- R1: While `rst_n` is low, `rd_data_valid`, `wr_data_en` and `proto_err` are 0 and every bank is idle. The configuration pins are captured on every clock while reset is held. Changes on them after reset is released have no effect on any spacing or latency.
- R2: Operation codes are NOP=0, ACTIVATE=1, READ=2, WRITE=3, PRECHARGE=4, AUTO-REFRESH=5. A command takes effect only on a cycle with `cmd_valid` and `cmd_ready` both high. A command presented with `cmd_valid` low changes nothing. NOP is always ready.
- R3: These commands are illegal: ACTIVATE to a bank whose row is open, READ or WRITE to an idle bank, AUTO-REFRESH while any bank is open, and codes 6 and 7. For an illegal command `cmd_ready` is 0 and `proto_err` equals `cmd_valid`.
- R4: A READ or WRITE to a bank is ready no earlier than tRCD cycles after the ACTIVATE that opened it.
- R5: A PRECHARGE to a bank is ready no earlier than tRAS cycles after that bank's ACTIVATE.
- R6: An ACTIVATE to a bank is ready no earlier than tRP cycles after that bank's PRECHARGE.
- R7: ACTIVATE or AUTO-REFRESH commands that touch the same bank are at least tRC cycles apart. AUTO-REFRESH touches every bank.
- R8: An ACTIVATE is ready no earlier than tRRD cycles after an ACTIVATE to a different bank.
- R9: Any two column commands (READ or WRITE, any banks) are at least tCCD cycles apart.
- R10: After a WRITE, a PRECHARGE to the same bank is ready no earlier than WL + 2 + tWR cycles later. That is the last data clock plus the write recovery time.
- R11: A READ issued in cycle g makes `rd_data_valid` high in cycles g+RL and g+RL+1, where RL = AL + CL.
- R12: A WRITE issued in cycle g makes `wr_data_en` high in cycles g+WL and g+WL+1, where WL = AL + CL − 1.
- R13: Each spacing is granted on exactly the first cycle it allows: a counter loaded with N releases the command N cycles after the one that loaded it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while low |
| cfg_tras | input | CNT_W | ACTIVATE to PRECHARGE, cycles |
| cfg_trp | input | CNT_W | PRECHARGE to ACTIVATE, cycles |
| cfg_trc | input | CNT_W | ACTIVATE/REFRESH to ACTIVATE/REFRESH in one bank, cycles |
| cfg_trrd | input | CNT_W | ACTIVATE to ACTIVATE in another bank, cycles |
| cfg_trcd | input | CNT_W | ACTIVATE to column command, cycles |
| cfg_tccd | input | CNT_W | Column command to column command, cycles |
| cfg_twr | input | CNT_W | Write recovery after last data, cycles |
| cfg_al | input | LAT_W | Additive latency |
| cfg_cl | input | LAT_W | CAS latency (2 or more) |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command may issue this cycle |
| cmd_op | input | 3 | Operation code |
| cmd_bank | input | BANK_W | Target bank |
| proto_err | output | 1 | Presented valid command is illegal |
| rd_data_valid | output | 1 | Read data beat pair returns this cycle |
| wr_data_en | output | 1 | Write data must be driven this cycle |

## Verification
The bench checks the spacings with chains of commands in which exactly one limit governs each grant, and it measures the wait exactly. ACTIVATE-to-PRECHARGE, PRECHARGE-to-ACTIVATE, row cycle, write recovery and bank-to-bank separation each appear as the binding limit in a separate position of a chain. A wrong counter therefore shows up as a wrong grant cycle and is not hidden by a neighbouring limit. Illegal patterns are presented and then withdrawn: a column command to a closed bank, a second activate, a refresh with rows open and the unused codes. A command held with valid low is followed by a probe showing the bank stayed closed. A scoreboard queue compares the read and write data windows beat by beat against the latencies captured at reset, after the configuration pins have been changed.

// File: rtl/ddr2_gate_pkg.sv
package ddr2_gate_pkg;
  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_ACT  = 3'd1,
    OP_RD   = 3'd2,
    OP_WR   = 3'd3,
    OP_PRE  = 3'd4,
    OP_REF  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } gate_op_e;
endpackage

// File: rtl/ddr2_bank_tracker.sv
module ddr2_bank_tracker #(
  parameter int CNT_W = 6,
  parameter int WRC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] t_ras,
  input  logic [CNT_W-1:0] t_rp,
  input  logic [CNT_W-1:0] t_rc,
  input  logic [CNT_W-1:0] t_rcd,
  input  logic [WRC_W-1:0] wr_hold,
  input  logic             act_go,
  input  logic             pre_go,
  input  logic             ref_go,
  input  logic             wr_go,
  output logic             row_open,
  output logic             act_ok,
  output logic             col_ok,
  output logic             pre_ok
);
  logic [CNT_W-1:0] ras_c, rp_c, rc_c, rcd_c;
  logic [WRC_W-1:0] wr_c;

  function automatic logic [CNT_W-1:0] span(input logic [CNT_W-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] tick(input logic [CNT_W-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_open <= 1'b0;
      ras_c <= '0; rp_c <= '0; rc_c <= '0; rcd_c <= '0; wr_c <= '0;
    end else begin
      if (act_go)      row_open <= 1'b1;
      else if (pre_go) row_open <= 1'b0;
      ras_c <= act_go ? span(t_ras) : tick(ras_c);
      rcd_c <= act_go ? span(t_rcd) : tick(rcd_c);
      rc_c  <= (act_go || ref_go) ? span(t_rc) : tick(rc_c);
      rp_c  <= pre_go ? span(t_rp) : tick(rp_c);
      if (wr_go)            wr_c <= wr_hold;
      else if (wr_c != '0)  wr_c <= wr_c - 1'b1;
    end
  end

  assign act_ok = !row_open && rp_c == '0 && rc_c == '0;
  assign col_ok = row_open && rcd_c == '0;
  assign pre_ok = ras_c == '0 && wr_c == '0;

  // ACTIVATE opens the row on the following cycle
  assert_open_after_act_R4: assert property (@(posedge clk) disable iff (!rst_n)
    act_go |=> row_open);
  // PRECHARGE closes the row on the following cycle
  assert_closed_after_pre_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_go && !act_go) |=> !row_open);
endmodule

// File: rtl/ddr2_burst_pipe.sv
module ddr2_burst_pipe #(
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic [LW-1:0] lat,
  output logic          beat
);
  localparam int LEN = (1 << LW) + 1;
  logic [LEN-1:0] pipe_q, pipe_d;

  always_comb begin
    pipe_d = pipe_q >> 1;
    if (fire && lat != '0) begin
      pipe_d[lat - 1'b1] = 1'b1;
      pipe_d[lat]        = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign beat = pipe_q[0];

  // every data window lasts at least two clocks (four beats)
  assert_burst_pair_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(beat) |=> beat);
endmodule

// File: rtl/ddr2_cmd_gate.sv
module ddr2_cmd_gate
  import ddr2_gate_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int CNT_W     = 6,
  parameter int LAT_W     = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cfg_tras,
  input  logic [CNT_W-1:0]  cfg_trp,
  input  logic [CNT_W-1:0]  cfg_trc,
  input  logic [CNT_W-1:0]  cfg_trrd,
  input  logic [CNT_W-1:0]  cfg_trcd,
  input  logic [CNT_W-1:0]  cfg_tccd,
  input  logic [CNT_W-1:0]  cfg_twr,
  input  logic [LAT_W-1:0]  cfg_al,
  input  logic [LAT_W-1:0]  cfg_cl,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [BANK_W-1:0] cmd_bank,
  output logic              proto_err,
  output logic              rd_data_valid,
  output logic              wr_data_en
);
  localparam int WRC_W = CNT_W + 2;
  localparam int RL_W  = LAT_W + 1;

  logic [CNT_W-1:0] tras_q, trp_q, trc_q, trrd_q, trcd_q, tccd_q, twr_q;
  logic [LAT_W-1:0] al_q, cl_q;

  // configuration held while reset is asserted
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tras_q <= cfg_tras; trp_q <= cfg_trp; trc_q <= cfg_trc;
      trrd_q <= cfg_trrd; trcd_q <= cfg_trcd; tccd_q <= cfg_tccd;
      twr_q <= cfg_twr; al_q <= cfg_al; cl_q <= cfg_cl;
    end
  end

  logic [RL_W-1:0]  rl, wl;
  logic [WRC_W-1:0] wr_hold;
  assign rl      = {1'b0, al_q} + {1'b0, cl_q};
  assign wl      = rl - 1'b1;
  assign wr_hold = WRC_W'(wl) + WRC_W'(twr_q) + WRC_W'(1);

  gate_op_e op;
  assign op = gate_op_e'(cmd_op);

  logic go, act_go, rd_go, wr_go, pre_go, ref_go, col_go;
  logic [NUM_BANKS-1:0] open_v, act_ok_v, col_ok_v, pre_ok_v;

  assign go     = cmd_valid && cmd_ready;
  assign act_go = go && op == OP_ACT;
  assign rd_go  = go && op == OP_RD;
  assign wr_go  = go && op == OP_WR;
  assign pre_go = go && op == OP_PRE;
  assign ref_go = go && op == OP_REF;
  assign col_go = rd_go || wr_go;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = cmd_bank == BANK_W'(b);
    ddr2_bank_tracker #(.CNT_W(CNT_W), .WRC_W(WRC_W)) u_trk (
      .clk(clk), .rst_n(rst_n),
      .t_ras(tras_q), .t_rp(trp_q), .t_rc(trc_q), .t_rcd(trcd_q),
      .wr_hold(wr_hold),
      .act_go(act_go && hit), .pre_go(pre_go && hit),
      .ref_go(ref_go), .wr_go(wr_go && hit),
      .row_open(open_v[b]), .act_ok(act_ok_v[b]),
      .col_ok(col_ok_v[b]), .pre_ok(pre_ok_v[b])
    );
  end

  // shared spacing counters
  logic [CNT_W-1:0]  rrd_c, ccd_c;
  logic [BANK_W-1:0] last_act;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rrd_c <= '0; ccd_c <= '0; last_act <= '0;
    end else begin
      if (act_go) begin
        rrd_c    <= (trrd_q == '0) ? '0 : trrd_q - 1'b1;
        last_act <= cmd_bank;
      end else if (rrd_c != '0) rrd_c <= rrd_c - 1'b1;
      if (col_go)             ccd_c <= (tccd_q == '0) ? '0 : tccd_q - 1'b1;
      else if (ccd_c != '0)   ccd_c <= ccd_c - 1'b1;
    end
  end

  logic illegal, timing_ok, sel_open;
  assign sel_open = open_v[cmd_bank];

  always_comb begin
    illegal   = 1'b0;
    timing_ok = 1'b1;
    case (op)
      OP_NOP: ;
      OP_ACT: begin
        illegal   = sel_open;
        timing_ok = act_ok_v[cmd_bank] && (rrd_c == '0 || last_act == cmd_bank);
      end
      OP_RD, OP_WR: begin
        illegal   = !sel_open;
        timing_ok = col_ok_v[cmd_bank] && ccd_c == '0;
      end
      OP_PRE: timing_ok = pre_ok_v[cmd_bank];
      OP_REF: begin
        illegal   = |open_v;
        timing_ok = &act_ok_v;
      end
      default: illegal = 1'b1;
    endcase
  end

  assign cmd_ready = rst_n && !illegal && timing_ok;
  assign proto_err = rst_n && cmd_valid && illegal;

  ddr2_burst_pipe #(.LW(RL_W)) u_rd_pipe (
    .clk(clk), .rst_n(rst_n), .fire(rd_go), .lat(rl), .beat(rd_data_valid));
  ddr2_burst_pipe #(.LW(RL_W)) u_wr_pipe (
    .clk(clk), .rst_n(rst_n), .fire(wr_go), .lat(wl), .beat(wr_data_en));

  // an illegal command is never granted
  assert_err_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> !cmd_ready);
  // two activates to different banks on adjacent cycles break the bank-to-bank gap
  assert_rrd_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (act_go && trrd_q >= 2) |=> !(act_go && cmd_bank != $past(cmd_bank)));
  // column commands on adjacent cycles break the column gap
  assert_ccd_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (col_go && tccd_q >= 2) |=> !col_go);
  // column command only ever reaches an open row
  assert_col_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
    col_go |-> sel_open);
endmodule

// File: tb/sim_ddr2_cmd_gate.sv
`timescale 1ns/1ps
module sim_ddr2_cmd_gate;
  localparam int CNT_W = 6, LAT_W = 4, NB = 8;
  localparam int TRAS = 6, TRP = 4, TRC = 12, TRRD = 2, TRCD = 3, TCCD = 2, TWR = 3;
  localparam int AL = 1, CL = 3, RL = AL + CL, WL = RL - 1;

  logic clk = 0, rst_n = 0;
  logic [CNT_W-1:0] tras, trp, trc, trrd, trcd, tccd, twr;
  logic [LAT_W-1:0] al, cl;
  logic cmd_valid = 0, cmd_ready, proto_err, rd_data_valid, wr_data_en;
  logic [2:0] cmd_op = 0;
  logic [2:0] cmd_bank = 0;

  ddr2_cmd_gate #(.NUM_BANKS(NB), .CNT_W(CNT_W), .LAT_W(LAT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_tras(tras), .cfg_trp(trp), .cfg_trc(trc),
    .cfg_trrd(trrd), .cfg_trcd(trcd), .cfg_tccd(tccd), .cfg_twr(twr),
    .cfg_al(al), .cfg_cl(cl), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_bank(cmd_bank), .proto_err(proto_err),
    .rd_data_valid(rd_data_valid), .wr_data_en(wr_data_en));

  always #10 clk = ~clk;

  int cyc = 0, tests = 0, fails = 0;
  int rdq[$], wrq[$];
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // scoreboard monitor: data windows against queued expected cycles
  always @(negedge clk) if (rst_n) begin
    bit er, ew;
    er = rdq.size() > 0 && rdq[0] == cyc;
    ew = wrq.size() > 0 && wrq[0] == cyc;
    if (er) void'(rdq.pop_front());
    if (ew) void'(wrq.pop_front());
    if (er || rd_data_valid) check("R11 rd_data_valid", int'(rd_data_valid), int'(er));
    if (ew || wr_data_en)    check("R12 wr_data_en", int'(wr_data_en), int'(ew));
  end

  // driver: present a command, wait for grant, push expected data windows
  task automatic issue(input logic [2:0] op, input logic [2:0] bank, output int g);
    @(negedge clk);
    cmd_op = op; cmd_bank = bank; cmd_valid = 1;
    #1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    g = cyc;
    if (op == 3'd2) begin rdq.push_back(g + RL); rdq.push_back(g + RL + 1); end
    if (op == 3'd3) begin wrq.push_back(g + WL); wrq.push_back(g + WL + 1); end
    @(posedge clk); #1;
    cmd_valid = 0; cmd_op = 0;
  endtask

  // present an illegal command, check refusal, then withdraw it
  task automatic probe_err(input logic [2:0] op, input logic [2:0] bank, input string req);
    @(negedge clk);
    cmd_op = op; cmd_bank = bank; cmd_valid = 1;
    #1;
    check({req, " ready"}, int'(cmd_ready), 0);
    check({req, " proto_err"}, int'(proto_err), 1);
    @(negedge clk);
    cmd_valid = 0; cmd_op = 0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    int a, r, w, p, a2, b, b2, pb, ab, rf, x;
    tras = TRAS; trp = TRP; trc = TRC; trrd = TRRD; trcd = TRCD;
    tccd = TCCD; twr = TWR; al = AL; cl = CL;
    repeat (4) @(negedge clk);
    check("R1 rd_data_valid in reset", int'(rd_data_valid), 0);
    check("R1 wr_data_en in reset", int'(wr_data_en), 0);
    cmd_valid = 1; cmd_op = 3'd2; #1;
    check("R1 proto_err in reset", int'(proto_err), 0);
    cmd_valid = 0; cmd_op = 0;
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    // R1: change configuration after release; must be ignored
    trcd = 1; tras = 1; trp = 1; trc = 1; trrd = 1; twr = 0; al = 0; cl = 2; tccd = 1;

    probe_err(3'd2, 3'd0, "R3 read to idle bank");
    probe_err(3'd7, 3'd0, "R3 reserved code");
    // R2: a command with valid low changes nothing
    @(negedge clk); cmd_op = 3'd1; cmd_bank = 3'd3; cmd_valid = 0;
    @(negedge clk); cmd_op = 0;
    probe_err(3'd3, 3'd3, "R2 write after unissued activate");
    @(negedge clk); cmd_op = 3'd0; cmd_valid = 1; #1;
    check("R2 NOP ready", int'(cmd_ready), 1);
    @(negedge clk); cmd_valid = 0;

    issue(3'd1, 3'd0, a);
    issue(3'd2, 3'd0, r);
    check("R4 R1 R13 tRCD act->read", r - a, TRCD);
    issue(3'd3, 3'd0, w);
    check("R9 tCCD read->write", w - r, TCCD);
    probe_err(3'd1, 3'd0, "R3 activate to open bank");
    issue(3'd4, 3'd0, p);
    check("R10 write->precharge", p - w, WL + 2 + TWR);
    issue(3'd1, 3'd0, a2);
    check("R6 tRP precharge->act", a2 - p, TRP);

    issue(3'd1, 3'd1, b);
    check("R8 tRRD act b0->b1", b - a2, TRRD);
    issue(3'd1, 3'd2, b2);
    check("R8 tRRD act b1->b2", b2 - b, TRRD);
    issue(3'd4, 3'd1, pb);
    check("R5 tRAS act->precharge", pb - b, TRAS);
    issue(3'd1, 3'd1, ab);
    check("R7 tRC act->act same bank", ab - b, TRC);
    probe_err(3'd5, 3'd0, "R3 refresh with open rows");

    issue(3'd4, 3'd0, x);
    issue(3'd4, 3'd1, x);
    issue(3'd4, 3'd2, x);
    issue(3'd5, 3'd0, rf);
    issue(3'd1, 3'd5, x);
    check("R7 tRC refresh->act other bank", x - rf, TRC);
    issue(3'd2, 3'd5, r);
    issue(3'd2, 3'd5, w);
    check("R9 tCCD read->read", w - r, TCCD);
    repeat (RL + 6) @(negedge clk);
    check("R11 read queue drained", rdq.size(), 0);
    check("R12 write queue drained", wrq.size(), 0);
    done = 1;
    summary();
  end
endmodule